// File: doc/BRIEF.md
# Banked Multiported Register File

This block is a 64 x 32-bit physical register store that presents eight global read ports and four global write ports while holding its contents in eight smaller banks. Each bank has only two read ports and two write ports. The read ports come in two groups of four: a left group for first source operands and a right group for second source operands. In every bank, one local read port feeds only the left group and the other feeds only the right group. An instruction can therefore pull both operands from one bank in the same cycle.

A register number splits into a bank index (its three low bits) and a word within that bank (its three high bits). An arbiter outside the block decides, for each bank and side, whether that local read port runs and which global port of that side supplies its word address. Every global read port that names a register in that bank then takes its data from that local port. This lets one local port serve several global ports that read the same register. On the write side, each global write port carries a slot bit that picks one of the two local write ports of the addressed bank.

Reads take one cycle: the data for an address presented before a rising edge appears after that edge, and stays until the next edge. Writes land on the rising edge. A read issued in the same cycle as a write to the same register returns the value held before the write.

Top module: `banked_regfile`

## Requirements
- R1: While reset is high at a rising edge, every global read output is zero after that edge.
- R2: A value written at one edge can be read from any global read port of either side. The read data appears after the edge at which the read address is sampled, so reads have a latency of one cycle.
- R3: Register number bits [2:0] select the bank and bits [5:3] select the word in that bank. All 64 registers hold independent values.
- R4: A left global port takes its data only from the left local port of its bank, and a right global port only from the right local port. The arbiter must enable that local port and aim it at a global port of the same side that carries the same word. The other side's local controls have no effect on the port.
- R5: In one cycle, a left port and a right port may read two different words of the same bank, and each returns its own register.
- R6: Several global ports of one side that read the same register in one cycle may all be served by a single local port, and all return that register.
- R7: A register read on the left and on the right in the same cycle uses both local ports of its bank, and both outputs return the same value.
- R8: A global read port whose enable was low at the sampling edge outputs zero.
- R9: A read sampled at the edge that writes the same register returns the old value. The new value is returned from the next edge on.
- R10: Each write port's slot bit (0 or 1) picks one of the two local write ports of its bank. Two write ports may write the same bank in one cycle through different slots. Two enabled write ports aimed at the same bank and the same slot are illegal input.
- R11: All four write ports may write four registers in distinct banks in one cycle, and all four values are retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rdl_en | input | 4 | Enable per left global read port |
| rdl_addr | input | 4x6 | Register number per left global read port |
| rdr_en | input | 4 | Enable per right global read port |
| rdr_addr | input | 4x6 | Register number per right global read port |
| lcl_l_en | input | 8 | Enable of the left local read port of each bank |
| lcl_l_sel | input | 8x2 | Left global port whose word address each bank's left local port uses |
| lcl_r_en | input | 8 | Enable of the right local read port of each bank |
| lcl_r_sel | input | 8x2 | Right global port whose word address each bank's right local port uses |
| wr_en | input | 4 | Enable per global write port |
| wr_addr | input | 4x6 | Register number per global write port |
| wr_slot | input | 4 | Local write slot (0 or 1) per global write port |
| wr_data | input | 4x32 | Write data per global write port |
| rdl_data | output | 4x32 | Read data of the left global ports |
| rdr_data | output | 4x32 | Read data of the right global ports |

## Verification
The assertions rely on a well-behaved arbiter. When a global read port is enabled, the local port of its side in its bank must be on and aimed at a global port with the same word. No two enabled write ports may share a bank and a slot. The bench plays that arbiter with a small combinational block: for each bank and side, it grants the lowest-numbered enabled global port that addresses that bank. Every scenario is built so that ports meeting in one bank and side always name the same register, and write ports sharing a bank always use different slots.

// File: rtl/brf_pkg.sv
package brf_pkg;
  // Side indices of the split read network
  localparam int unsigned SIDE_LEFT  = 0;
  localparam int unsigned SIDE_RIGHT = 1;
  localparam int unsigned NUM_SIDES  = 2;
  // Local write ports per bank, chosen by a one-bit slot
  localparam int unsigned LOCAL_WR   = 2;

  // Width of a select field able to name one of n items
  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rf_write_steer.sv
module rf_write_steer
  import brf_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned WR_PORTS  = 4,
  parameter int unsigned BANK_W    = 3,
  parameter int unsigned WORD_W    = 3,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned ADDR_W   = BANK_W + WORD_W
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic [WR_PORTS-1:0]                           wr_en,
  input  logic [WR_PORTS-1:0][ADDR_W-1:0]               wr_addr,
  input  logic [WR_PORTS-1:0]                           wr_slot,
  input  logic [WR_PORTS-1:0][DATA_W-1:0]               wr_data,
  output logic [NUM_BANKS-1:0][LOCAL_WR-1:0]             bw_en,
  output logic [NUM_BANKS-1:0][LOCAL_WR-1:0][WORD_W-1:0] bw_word,
  output logic [NUM_BANKS-1:0][LOCAL_WR-1:0][DATA_W-1:0] bw_data
);

  // Route every global write port to the local slot of its bank
  always_comb begin
    bw_en   = '0;
    bw_word = '0;
    bw_data = '0;
    for (int p = 0; p < int'(WR_PORTS); p++) begin
      if (wr_en[p]) begin
        bw_en  [wr_addr[p][BANK_W-1:0]][wr_slot[p]] = 1'b1;
        bw_word[wr_addr[p][BANK_W-1:0]][wr_slot[p]] = wr_addr[p][ADDR_W-1:BANK_W];
        bw_data[wr_addr[p][BANK_W-1:0]][wr_slot[p]] = wr_data[p];
      end
    end
  end

  // Input rule: no two enabled write ports may meet in one bank slot
  for (genvar a = 0; a < WR_PORTS; a++) begin : g_wa
    for (genvar b = a + 1; b < WR_PORTS; b++) begin : g_wb
      AST_WR_SLOT_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        (wr_en[a] && wr_en[b]) |->
          ((wr_addr[a][BANK_W-1:0] != wr_addr[b][BANK_W-1:0]) || (wr_slot[a] != wr_slot[b])))
        else $error("two write ports share a bank slot"); // R10
    end
  end

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned WORD_W = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_WR   = 2,
  parameter int unsigned N_RD   = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_WR-1:0]              wr_en,
  input  logic [N_WR-1:0][WORD_W-1:0]  wr_word,
  input  logic [N_WR-1:0][DATA_W-1:0]  wr_data,
  input  logic [N_RD-1:0]              rd_en,
  input  logic [N_RD-1:0][WORD_W-1:0]  rd_word,
  output logic [N_RD-1:0][DATA_W-1:0]  rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage writes; a higher slot wins on a shared word
  always_ff @(posedge clk) begin
    for (int w = 0; w < int'(N_WR); w++) begin
      if (wr_en[w]) mem[wr_word[w]] <= wr_data[w];
    end
  end

  // Registered reads, old data on a same-edge write
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      for (int r = 0; r < int'(N_RD); r++) begin
        if (rd_en[r]) rd_data[r] <= mem[rd_word[r]];
      end
    end
  end

endmodule

// File: rtl/rf_read_xbar.sv
module rf_read_xbar
  import brf_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 8,
  parameter int unsigned SIDE_PORTS = 4,
  parameter int unsigned BANK_W     = 3,
  parameter int unsigned WORD_W     = 3,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned ADDR_W    = BANK_W + WORD_W,
  localparam int unsigned SEL_W     = sel_width(SIDE_PORTS)
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [SIDE_PORTS-1:0]                g_en,
  input  logic [SIDE_PORTS-1:0][ADDR_W-1:0]    g_addr,
  input  logic [NUM_BANKS-1:0]                 lc_en,
  input  logic [NUM_BANKS-1:0][SEL_W-1:0]      lc_sel,
  output logic [NUM_BANKS-1:0][WORD_W-1:0]     lp_word,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]     lp_rdata,
  output logic [SIDE_PORTS-1:0][DATA_W-1:0]    g_data
);

  logic [SIDE_PORTS-1:0]             g_en_q;
  logic [SIDE_PORTS-1:0][BANK_W-1:0] g_bank_q;

  // Each local port takes the word of the global port it was granted to
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lp
    assign lp_word[b] = g_addr[lc_sel[b]][ADDR_W-1:BANK_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      g_en_q   <= '0;
      g_bank_q <= '0;
    end else begin
      g_en_q <= g_en;
      for (int p = 0; p < int'(SIDE_PORTS); p++) g_bank_q[p] <= g_addr[p][BANK_W-1:0];
    end
  end

  // Global bus mux: one local port may feed several global ports
  for (genvar p = 0; p < SIDE_PORTS; p++) begin : g_out
    assign g_data[p] = g_en_q[p] ? lp_rdata[g_bank_q[p]] : '0;

    AST_LOCAL_GRANT: assert property (@(posedge clk) disable iff (rst)
      g_en[p] |-> (lc_en[g_addr[p][BANK_W-1:0]] &&
        (g_addr[lc_sel[g_addr[p][BANK_W-1:0]]][ADDR_W-1:BANK_W] == g_addr[p][ADDR_W-1:BANK_W])))
      else $error("global read port lacks a matching local grant"); // R4

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !g_en[p] |=> (g_data[p] == '0))
      else $error("idle global read port not zero"); // R8

    for (genvar q = p + 1; q < SIDE_PORTS; q++) begin : g_sh
      AST_SHARE_EQUAL: assert property (@(posedge clk) disable iff (rst)
        (g_en[p] && g_en[q] && (g_addr[p] == g_addr[q])) |=> (g_data[p] == g_data[q]))
        else $error("shared read returned different data"); // R6
    end
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int unsigned NUM_REGS   = 64,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_BANKS  = 8,
  parameter int unsigned SIDE_PORTS = 4,
  parameter int unsigned WR_PORTS   = 4,
  localparam int unsigned ADDR_W    = $clog2(NUM_REGS),
  localparam int unsigned BANK_W    = $clog2(NUM_BANKS),
  localparam int unsigned SEL_W     = sel_width(SIDE_PORTS)
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [SIDE_PORTS-1:0]                rdl_en,
  input  logic [SIDE_PORTS-1:0][ADDR_W-1:0]    rdl_addr,
  input  logic [SIDE_PORTS-1:0]                rdr_en,
  input  logic [SIDE_PORTS-1:0][ADDR_W-1:0]    rdr_addr,
  input  logic [NUM_BANKS-1:0]                 lcl_l_en,
  input  logic [NUM_BANKS-1:0][SEL_W-1:0]      lcl_l_sel,
  input  logic [NUM_BANKS-1:0]                 lcl_r_en,
  input  logic [NUM_BANKS-1:0][SEL_W-1:0]      lcl_r_sel,
  input  logic [WR_PORTS-1:0]                  wr_en,
  input  logic [WR_PORTS-1:0][ADDR_W-1:0]      wr_addr,
  input  logic [WR_PORTS-1:0]                  wr_slot,
  input  logic [WR_PORTS-1:0][DATA_W-1:0]      wr_data,
  output logic [SIDE_PORTS-1:0][DATA_W-1:0]    rdl_data,
  output logic [SIDE_PORTS-1:0][DATA_W-1:0]    rdr_data
);

  localparam int unsigned WORD_W = ADDR_W - BANK_W;
  localparam int unsigned DEPTH  = NUM_REGS / NUM_BANKS;

  // Write steering outputs
  logic [NUM_BANKS-1:0][LOCAL_WR-1:0]             bw_en;
  logic [NUM_BANKS-1:0][LOCAL_WR-1:0][WORD_W-1:0] bw_word;
  logic [NUM_BANKS-1:0][LOCAL_WR-1:0][DATA_W-1:0] bw_data;

  // Read network, indexed by side
  logic [NUM_SIDES-1:0][SIDE_PORTS-1:0]              g_en;
  logic [NUM_SIDES-1:0][SIDE_PORTS-1:0][ADDR_W-1:0]  g_addr;
  logic [NUM_SIDES-1:0][NUM_BANKS-1:0]               lc_en;
  logic [NUM_SIDES-1:0][NUM_BANKS-1:0][SEL_W-1:0]    lc_sel;
  logic [NUM_SIDES-1:0][NUM_BANKS-1:0][WORD_W-1:0]   lp_word;
  logic [NUM_SIDES-1:0][NUM_BANKS-1:0][DATA_W-1:0]   lp_rdata;
  logic [NUM_SIDES-1:0][SIDE_PORTS-1:0][DATA_W-1:0]  g_data;

  assign g_en  [SIDE_LEFT]  = rdl_en;
  assign g_en  [SIDE_RIGHT] = rdr_en;
  assign g_addr[SIDE_LEFT]  = rdl_addr;
  assign g_addr[SIDE_RIGHT] = rdr_addr;
  assign lc_en [SIDE_LEFT]  = lcl_l_en;
  assign lc_en [SIDE_RIGHT] = lcl_r_en;
  assign lc_sel[SIDE_LEFT]  = lcl_l_sel;
  assign lc_sel[SIDE_RIGHT] = lcl_r_sel;
  assign rdl_data = g_data[SIDE_LEFT];
  assign rdr_data = g_data[SIDE_RIGHT];

  rf_write_steer #(
    .NUM_BANKS(NUM_BANKS), .WR_PORTS(WR_PORTS), .BANK_W(BANK_W),
    .WORD_W(WORD_W), .DATA_W(DATA_W)
  ) u_wsteer (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_slot(wr_slot), .wr_data(wr_data),
    .bw_en(bw_en), .bw_word(bw_word), .bw_data(bw_data)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    rf_read_xbar #(
      .NUM_BANKS(NUM_BANKS), .SIDE_PORTS(SIDE_PORTS), .BANK_W(BANK_W),
      .WORD_W(WORD_W), .DATA_W(DATA_W)
    ) u_xbar (
      .clk(clk), .rst(rst),
      .g_en(g_en[s]), .g_addr(g_addr[s]),
      .lc_en(lc_en[s]), .lc_sel(lc_sel[s]),
      .lp_word(lp_word[s]), .lp_rdata(lp_rdata[s]),
      .g_data(g_data[s])
    );
  end

  // Local read port 0 feeds the left side, port 1 the right side
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [NUM_SIDES-1:0][DATA_W-1:0] bank_rd;

    rf_bank #(
      .DEPTH(DEPTH), .WORD_W(WORD_W), .DATA_W(DATA_W),
      .N_WR(LOCAL_WR), .N_RD(NUM_SIDES)
    ) u_bank (
      .clk(clk), .rst(rst),
      .wr_en(bw_en[b]), .wr_word(bw_word[b]), .wr_data(bw_data[b]),
      .rd_en({lc_en[SIDE_RIGHT][b], lc_en[SIDE_LEFT][b]}),
      .rd_word({lp_word[SIDE_RIGHT][b], lp_word[SIDE_LEFT][b]}),
      .rd_data(bank_rd)
    );

    assign lp_rdata[SIDE_LEFT][b]  = bank_rd[SIDE_LEFT];
    assign lp_rdata[SIDE_RIGHT][b] = bank_rd[SIDE_RIGHT];
  end

  // A register read on both sides yields equal data through two local ports
  for (genvar p = 0; p < SIDE_PORTS; p++) begin : g_bl
    for (genvar q = 0; q < SIDE_PORTS; q++) begin : g_br
      AST_BOTH_SIDES: assert property (@(posedge clk) disable iff (rst)
        (rdl_en[p] && rdr_en[q] && (rdl_addr[p] == rdr_addr[q])) |=> (rdl_data[p] == rdr_data[q]))
        else $error("left and right reads of one register differ"); // R7
    end
  end

endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 64;
  localparam int DW = 32;
  localparam int NB = 8;
  localparam int SP = 4;
  localparam int WP = 4;
  localparam int AW = 6;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SP-1:0]          rdl_en = '0, rdr_en = '0;
  logic [SP-1:0][AW-1:0]  rdl_addr = '0, rdr_addr = '0;
  logic [NB-1:0]          lcl_l_en, lcl_r_en;
  logic [NB-1:0][SW-1:0]  lcl_l_sel, lcl_r_sel;
  logic [WP-1:0]          wr_en = '0, wr_slot = '0;
  logic [WP-1:0][AW-1:0]  wr_addr = '0;
  logic [WP-1:0][DW-1:0]  wr_data = '0;
  logic [SP-1:0][DW-1:0]  rdl_data, rdr_data;

  logic [DW-1:0] exp_mem [NR];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst(rst),
    .rdl_en(rdl_en), .rdl_addr(rdl_addr), .rdr_en(rdr_en), .rdr_addr(rdr_addr),
    .lcl_l_en(lcl_l_en), .lcl_l_sel(lcl_l_sel), .lcl_r_en(lcl_r_en), .lcl_r_sel(lcl_r_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_slot(wr_slot), .wr_data(wr_data),
    .rdl_data(rdl_data), .rdr_data(rdr_data)
  );

  // Bench arbiter: lowest enabled port of a side addressing a bank wins it
  always_comb begin
    lcl_l_en = '0; lcl_l_sel = '0; lcl_r_en = '0; lcl_r_sel = '0;
    for (int b = 0; b < NB; b++) begin
      for (int p = SP - 1; p >= 0; p--) begin
        if (rdl_en[p] && (int'(rdl_addr[p][2:0]) == b)) begin
          lcl_l_en[b] = 1'b1; lcl_l_sel[b] = SW'(p);
        end
        if (rdr_en[p] && (int'(rdr_addr[p][2:0]) == b)) begin
          lcl_r_en[b] = 1'b1; lcl_r_sel[b] = SW'(p);
        end
      end
    end
  end

  function automatic logic [DW-1:0] pat(input int r, input int salt);
    return 32'hC0DE0000 + DW'(r) * 32'h00010111 + DW'(salt) * 32'h11000000;
  endfunction

  task automatic check(input string req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic idle_inputs();
    rdl_en = '0; rdr_en = '0; rdl_addr = '0; rdr_addr = '0;
    wr_en = '0; wr_slot = '0; wr_addr = '0; wr_data = '0;
  endtask

  // One edge, then sample half a period later
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    for (int p = 0; p < SP; p++) begin
      check("R1", "left after reset", rdl_data[p], '0);
      check("R1", "right after reset", rdr_data[p], '0);
    end
  endtask

  // Four writes per cycle into four distinct banks, all 64 registers
  task automatic t_fill();
    for (int c = 0; c < NR / WP; c++) begin
      for (int p = 0; p < WP; p++) begin
        wr_en[p] = 1'b1; wr_addr[p] = AW'(c * WP + p); wr_slot[p] = 1'b0;
        wr_data[p] = pat(c * WP + p, 0);
        exp_mem[c * WP + p] = pat(c * WP + p, 0);
      end
      tick();
    end
    idle_inputs();
  endtask

  // Left reads 8c+0..3, right reads 8c+4..7: every bank used once per cycle
  task automatic t_readback();
    for (int c = 0; c < NR / 8; c++) begin
      for (int p = 0; p < SP; p++) begin
        rdl_en[p] = 1'b1; rdl_addr[p] = AW'(8 * c + p);
        rdr_en[p] = 1'b1; rdr_addr[p] = AW'(8 * c + 4 + p);
      end
      tick();
      for (int p = 0; p < SP; p++) begin
        check("R3", "left readback", rdl_data[p], exp_mem[8 * c + p]);
        check("R2", "right readback", rdr_data[p], exp_mem[8 * c + 4 + p]);
      end
    end
    idle_inputs();
  endtask

  task automatic t_read_during_write();
    rdl_en[0] = 1'b1; rdl_addr[0] = 6'd9;
    wr_en[2] = 1'b1; wr_addr[2] = 6'd9; wr_slot[2] = 1'b1; wr_data[2] = pat(9, 5);
    tick();
    check("R9", "read at writing edge gives old", rdl_data[0], exp_mem[9]);
    exp_mem[9] = pat(9, 5);
    wr_en = '0;
    tick();
    check("R9", "read after write gives new", rdl_data[0], exp_mem[9]);
    check("R2", "one-cycle read latency", rdl_data[0], pat(9, 5));
    idle_inputs();
  endtask

  // Bank 2: left reads word 0 (reg 2), right reads word 1 (reg 10)
  task automatic t_same_bank();
    rdl_en[1] = 1'b1; rdl_addr[1] = 6'd2;
    rdr_en[3] = 1'b1; rdr_addr[3] = 6'd10;
    tick();
    check("R5", "left operand same bank", rdl_data[1], exp_mem[2]);
    check("R5", "right operand same bank", rdr_data[3], exp_mem[10]);
    check("R4", "left port ignores right local word", rdl_data[1], exp_mem[2]);
    idle_inputs();
  endtask

  task automatic t_share();
    for (int p = 0; p < SP; p++) begin
      rdl_en[p] = 1'b1; rdl_addr[p] = 6'd13;
      rdr_en[p] = 1'b1; rdr_addr[p] = (p < 2) ? 6'd21 : 6'd30;
    end
    tick();
    for (int p = 0; p < SP; p++) begin
      check("R6", "left shared read", rdl_data[p], exp_mem[13]);
      check("R6", "right shared read", rdr_data[p], (p < 2) ? exp_mem[21] : exp_mem[30]);
    end
    idle_inputs();
  endtask

  task automatic t_both_sides();
    rdl_en[1] = 1'b1; rdl_addr[1] = 6'd44;
    rdr_en[2] = 1'b1; rdr_addr[2] = 6'd44;
    tick();
    check("R7", "left of dual-side read", rdl_data[1], exp_mem[44]);
    check("R7", "right of dual-side read", rdr_data[2], exp_mem[44]);
    idle_inputs();
  endtask

  task automatic t_disabled();
    rdl_en[0] = 1'b1; rdl_addr[0] = 6'd5;
    tick();
    check("R8", "enabled port", rdl_data[0], exp_mem[5]);
    for (int p = 1; p < SP; p++) check("R8", "disabled left port", rdl_data[p], '0);
    for (int p = 0; p < SP; p++) check("R8", "disabled right port", rdr_data[p], '0);
    rdl_en[0] = 1'b0;
    tick();
    check("R8", "port after disable", rdl_data[0], '0);
    idle_inputs();
  endtask

  // Bank 3 slots 0/1 (regs 3, 59) and bank 6 slots 0/1 (regs 14, 22) together
  task automatic t_slots();
    wr_en = 4'hF;
    wr_addr[0] = 6'd3;  wr_slot[0] = 1'b0; wr_data[0] = pat(3, 7);
    wr_addr[1] = 6'd59; wr_slot[1] = 1'b1; wr_data[1] = pat(59, 7);
    wr_addr[2] = 6'd14; wr_slot[2] = 1'b1; wr_data[2] = pat(14, 7);
    wr_addr[3] = 6'd22; wr_slot[3] = 1'b0; wr_data[3] = pat(22, 7);
    exp_mem[3] = pat(3, 7); exp_mem[59] = pat(59, 7);
    exp_mem[14] = pat(14, 7); exp_mem[22] = pat(22, 7);
    tick();
    idle_inputs();
    rdl_en[0] = 1'b1; rdl_addr[0] = 6'd3;
    rdr_en[0] = 1'b1; rdr_addr[0] = 6'd59;
    rdl_en[1] = 1'b1; rdl_addr[1] = 6'd14;
    rdr_en[1] = 1'b1; rdr_addr[1] = 6'd22;
    tick();
    check("R10", "bank 3 slot 0", rdl_data[0], exp_mem[3]);
    check("R10", "bank 3 slot 1", rdr_data[0], exp_mem[59]);
    check("R10", "bank 6 slot 1", rdl_data[1], exp_mem[14]);
    check("R11", "bank 6 slot 0", rdr_data[1], exp_mem[22]);
    idle_inputs();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill();
    t_readback();
    t_read_during_write();
    t_same_bank();
    t_share();
    t_both_sides();
    t_disabled();
    t_slots();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule